// File: doc/BRIEF.md
# Disk Controller Phase Status Sequencer

This block follows a floppy-style disk controller through the three phases of every command: command bytes arrive from the host, an optional execution phase moves data, and result bytes return to the host. From that progress it builds the read-only main status byte that host software polls before each data-register access. The host reaches the block through a small register window. One offset holds the status byte and can be read at any time without side effects. A second offset is the data register, which carries command, data and result bytes.

The first command byte is decoded against an internal table. The table gives how many command bytes follow, whether an execution phase exists and in which direction it moves data, and how many result bytes come back. Opcodes that are not in the table complete after one byte and return a single invalid-command result. The core side of the controller sees each accepted host byte and a completion strobe carrying the opcode. It requests execution bytes one at a time, signals the end of execution, and supplies result bytes by index. It also reports per-drive seek activity, which the block mirrors into the status byte.

A host access is accepted only when the ready bit is set and the access direction matches the direction bit. After every accepted access the ready bit drops for one clock before it reports the next state. This gap lets software that polls straight after a transfer see fresh status.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset the status byte reads 0x80: ready (bit 7) is 1, and direction (bit 6), non-DMA (bit 5), busy (bit 4) and the drive bits are 0 apart from the live seek inputs.
- R2: The status byte sits at offset 4. Reading it has no effect on any phase, count or ready state. Bits 3 and 2 always read 0.
- R3: An accepted data-register access (offset 5) clears ready for exactly one clock. Ready then returns if the current phase expects another host byte. A data access made while ready is 0, or in the direction opposite to bit 6, is ignored.
- R4: Busy (bit 4) becomes 1 with the first accepted command byte and stays 1 until the last result byte has been read.
- R5: Opcode low bits 0x0F (3 bytes) and 0x07 (2 bytes) have no result phase. Busy clears and the status byte returns to 0x80 right after their last command byte.
- R6: Opcode low bits 0x08 take 1 byte and return 2 results. Opcode low bits 0x06 and 0x05 take 9 bytes, run an execution phase, and return 7 results. Opcode bits 7..5 do not affect decoding.
- R7: Any other opcode ends after its single byte and returns one result byte, 0x80.
- R8: Direction (bit 6) is 0 in the command phase and 1 in the result phase. During execution it is 1 for opcode 0x06 (host reads) and 0 for opcode 0x05 (host writes).
- R9: When the non-DMA mode input is 1 at the first command byte, bit 5 is 1 exactly during execution. Each core data request raises ready for one host byte; an execution read returns the byte given with the request. Execution done moves to the result phase.
- R10: When the non-DMA mode input is 0 at the first command byte, ready and bit 5 stay 0 throughout execution.
- R11: Status bits 0 and 1 follow the seek-active inputs of drives 0 and 1 in every phase.
- R12: After the last command byte, the completion output pulses for one clock and carries the first command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_sel | input | 1 | Host access strobe for the current cycle |
| hst_wr | input | 1 | 1 for a host write, 0 for a read |
| hst_addr | input | ADDR_W | Offset inside the controller window |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte (status or data) |
| nondma_mode | input | 1 | Polled execution mode, latched at the first command byte |
| seek_busy | input | DRIVES | Per-drive seek activity from the core |
| core_xreq | input | 1 | Execution byte request from the core |
| core_xdata | input | 8 | Execution byte offered to the host with a request |
| core_xdone | input | 1 | End of execution phase |
| core_res_byte | input | 8 | Result byte selected by res_idx |
| res_idx | output | 4 | Index of the result byte being offered |
| cmd_go | output | 1 | One-clock pulse after the last command byte |
| cmd_op | output | 8 | First byte of the current command |
| par_vld | output | 1 | A host write byte is accepted this cycle |
| par_data | output | 8 | Accepted host write byte |
| par_idx | output | 4 | Position of the accepted byte within its phase |
| xfer_rd_ack | output | 1 | Host took an execution read byte this cycle |

## Verification
The assertions assume the core raises a data request only during execution and only while ready is low. They also assume execution done comes only during execution and never in the same cycle as a request or a host access. The bench keeps to these rules. It issues each request only after the previous byte has been moved, and it pulses execution done only after the last execution byte has been handled. Host accesses are driven as isolated single-cycle strobes, apart from the directed cases that deliberately try an access during the one-clock gap or in the wrong direction.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

   localparam int unsigned LEN_W = 4;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_EXEC = 2'd2,
      PH_RES  = 2'd3
   } phase_e;

   typedef struct packed {
      logic [LEN_W-1:0] cmd_len;
      logic [LEN_W-1:0] res_cnt;
      logic             has_exec;
      logic             exec_rd;
      logic             bad_op;
   } cmd_info_t;

   localparam logic [7:0] BAD_OP_RESULT = 8'h80;

   function automatic phase_e phase_after_cmd(input cmd_info_t ci);
      if (ci.has_exec)
         return PH_EXEC;
      else if (ci.res_cnt != '0)
         return PH_RES;
      else
         return PH_IDLE;
   endfunction

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
   import fdc_seq_pkg::*;
(
   input  logic [7:0] opcode,
   output cmd_info_t  info
);

   always_comb begin
      info = '0;
      casez (opcode)
         8'b???0_1111: begin   // head positioning
            info.cmd_len = LEN_W'(3);
         end
         8'b???0_0111: begin   // return to track zero
            info.cmd_len = LEN_W'(2);
         end
         8'b???0_1000: begin   // interrupt status query
            info.cmd_len = LEN_W'(1);
            info.res_cnt = LEN_W'(2);
         end
         8'b???0_0110: begin   // sector read, host receives
            info.cmd_len  = LEN_W'(9);
            info.res_cnt  = LEN_W'(7);
            info.has_exec = 1'b1;
            info.exec_rd  = 1'b1;
         end
         8'b???0_0101: begin   // sector write, host sends
            info.cmd_len  = LEN_W'(9);
            info.res_cnt  = LEN_W'(7);
            info.has_exec = 1'b1;
         end
         default: begin
            info.cmd_len = LEN_W'(1);
            info.res_cnt = LEN_W'(1);
            info.bad_op  = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/fdc_phase_fsm.sv
module fdc_phase_fsm
   import fdc_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             rd_req,
   input  logic [7:0]       wdata,
   input  cmd_info_t        dec_info,
   input  logic             nondma_in,
   input  logic             core_xreq,
   input  logic             core_xdone,
   output phase_e           phase,
   output logic             rqm,
   output logic             dio,
   output logic             busy,
   output logic             ndma,
   output logic [LEN_W-1:0] cnt,
   output cmd_info_t        info_q,
   output logic             go,
   output logic [7:0]       op_q,
   output logic             take_wr,
   output logic             take_rd
);

   logic             mode_q;
   logic [LEN_W-1:0] cnt_nxt;
   logic             cmd_last;
   logic             res_last;

   assign dio     = (phase == PH_RES) || ((phase == PH_EXEC) && info_q.exec_rd);
   assign busy    = (phase != PH_IDLE);
   assign ndma    = (phase == PH_EXEC) && mode_q;
   assign take_wr = wr_req && rqm && !dio;
   assign take_rd = rd_req && rqm && dio;

   assign cnt_nxt  = LEN_W'(cnt + 1'b1);
   assign cmd_last = (cnt_nxt == info_q.cmd_len);
   assign res_last = (cnt_nxt == info_q.res_cnt);

   // ready bit: drops on any accepted byte, returns one clock later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rqm <= 1'b1;
      end else if (take_wr || take_rd) begin
         rqm <= 1'b0;
      end else if (phase == PH_EXEC) begin
         if (core_xdone)
            rqm <= 1'b0;
         else if (core_xreq && mode_q)
            rqm <= 1'b1;
      end else begin
         rqm <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         info_q <= '0;
         mode_q <= 1'b0;
         go     <= 1'b0;
         op_q   <= '0;
      end else begin
         go <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (take_wr) begin
                  info_q <= dec_info;
                  op_q   <= wdata;
                  mode_q <= nondma_in;
                  if (dec_info.cmd_len == LEN_W'(1)) begin
                     go    <= 1'b1;
                     cnt   <= '0;
                     phase <= phase_after_cmd(dec_info);
                  end else begin
                     cnt   <= LEN_W'(1);
                     phase <= PH_CMD;
                  end
               end
            end
            PH_CMD: begin
               if (take_wr) begin
                  if (cmd_last) begin
                     go    <= 1'b1;
                     cnt   <= '0;
                     phase <= phase_after_cmd(info_q);
                  end else begin
                     cnt <= cnt_nxt;
                  end
               end
            end
            PH_EXEC: begin
               if (core_xdone) begin
                  cnt   <= '0;
                  phase <= PH_RES;
               end
            end
            PH_RES: begin
               if (take_rd) begin
                  if (res_last) begin
                     cnt   <= '0;
                     phase <= PH_IDLE;
                  end else begin
                     cnt <= cnt_nxt;
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R3: every accepted byte is followed by a cleared ready bit
   p_rqm_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_wr || take_rd) |=> !rqm);

   // R4: the first command byte always leaves the idle phase
   p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && take_wr) |=> busy);

   // R5: commands without results return to idle after their last byte
   p_short_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CMD && take_wr && cmd_last && !info_q.has_exec
       && info_q.res_cnt == '0) |=> (phase == PH_IDLE));

   // R10: DMA-mode execution never offers the data register
   p_dma_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_EXEC && !mode_q && $past(phase) == PH_EXEC) |-> !rqm);

   // R9: core requests only arrive during execution with ready low
   p_xreq_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_xreq |-> (phase == PH_EXEC && !rqm && !core_xdone));

   // R12: the completion strobe lasts one clock
   p_go_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !go);

   // R1: idle with no access in the previous cycle means ready
   p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && $past(phase) == PH_IDLE && !$past(take_wr)
       && !$past(take_rd)) |-> rqm);

endmodule

// File: rtl/fdc_host_port.sv
module fdc_host_port
   import fdc_seq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned STAT_OFS = 4,
   parameter int unsigned DATA_OFS = 5,
   parameter int unsigned DRIVES   = 2,
   parameter bit          RD_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic              rqm,
   input  logic              dio,
   input  logic              ndma,
   input  logic              busy,
   input  logic [DRIVES-1:0] seek_busy,
   input  phase_e            phase,
   input  logic              bad_op,
   input  logic              core_xreq,
   input  logic [7:0]        core_xdata,
   input  logic [7:0]        core_res_byte,
   output logic              wr_req,
   output logic              rd_req,
   output logic [7:0]        hst_rdata
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

   logic [1:0] drv_bits;
   logic [7:0] status;
   logic [7:0] xdata_q;
   logic [7:0] data_mux;
   logic [7:0] rd_mux;

   assign wr_req = hst_sel && hst_wr && (hst_addr == DATA_A);
   assign rd_req = hst_sel && !hst_wr && (hst_addr == DATA_A);

   for (genvar d = 0; d < 2; d++) begin : g_drv
      if (d < DRIVES) begin : g_live
         assign drv_bits[d] = seek_busy[d];
      end else begin : g_tied
         assign drv_bits[d] = 1'b0;
      end
   end

   assign status = {rqm, dio, ndma, busy, 2'b00, drv_bits};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         xdata_q <= '0;
      else if (core_xreq && phase == PH_EXEC)
         xdata_q <= core_xdata;
   end

   always_comb begin
      unique case (phase)
         PH_RES:  data_mux = bad_op ? BAD_OP_RESULT : core_res_byte;
         PH_EXEC: data_mux = xdata_q;
         default: data_mux = '0;
      endcase
   end

   assign rd_mux = (hst_addr == STAT_A) ? status :
                   (hst_addr == DATA_A) ? data_mux : 8'h00;

   if (RD_REG) begin : g_rd_reg
      logic [7:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (hst_sel && !hst_wr)
            rdata_q <= rd_mux;
      end
      assign hst_rdata = rdata_q;
   end else begin : g_rd_comb
      assign hst_rdata = rd_mux;
   end

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
   import fdc_seq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned STAT_OFS = 4,
   parameter int unsigned DATA_OFS = 5,
   parameter int unsigned DRIVES   = 2,
   parameter bit          RD_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [7:0]        hst_wdata,
   output logic [7:0]        hst_rdata,
   input  logic              nondma_mode,
   input  logic [DRIVES-1:0] seek_busy,
   input  logic              core_xreq,
   input  logic [7:0]        core_xdata,
   input  logic              core_xdone,
   input  logic [7:0]        core_res_byte,
   output logic [LEN_W-1:0]  res_idx,
   output logic              cmd_go,
   output logic [7:0]        cmd_op,
   output logic              par_vld,
   output logic [7:0]        par_data,
   output logic [LEN_W-1:0]  par_idx,
   output logic              xfer_rd_ack
);

   if (DRIVES < 1 || DRIVES > 2) begin : g_bad_drives
      $error("DRIVES must be 1 or 2");
   end
   if (STAT_OFS == DATA_OFS) begin : g_bad_ofs
      $error("status and data offsets must differ");
   end
   if (STAT_OFS >= (1 << ADDR_W) || DATA_OFS >= (1 << ADDR_W)) begin : g_bad_win
      $error("offsets must fit the address width");
   end

   cmd_info_t        dec_info;
   cmd_info_t        info_q;
   phase_e           phase;
   logic             rqm, dio, busy, ndma;
   logic [LEN_W-1:0] cnt;
   logic             wr_req, rd_req, take_wr, take_rd;

   fdc_cmd_decode u_dec (
      .opcode (hst_wdata),
      .info   (dec_info)
   );

   fdc_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_req     (wr_req),
      .rd_req     (rd_req),
      .wdata      (hst_wdata),
      .dec_info   (dec_info),
      .nondma_in  (nondma_mode),
      .core_xreq  (core_xreq),
      .core_xdone (core_xdone),
      .phase      (phase),
      .rqm        (rqm),
      .dio        (dio),
      .busy       (busy),
      .ndma       (ndma),
      .cnt        (cnt),
      .info_q     (info_q),
      .go         (cmd_go),
      .op_q       (cmd_op),
      .take_wr    (take_wr),
      .take_rd    (take_rd)
   );

   fdc_host_port #(
      .ADDR_W   (ADDR_W),
      .STAT_OFS (STAT_OFS),
      .DATA_OFS (DATA_OFS),
      .DRIVES   (DRIVES),
      .RD_REG   (RD_REG)
   ) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .hst_sel       (hst_sel),
      .hst_wr        (hst_wr),
      .hst_addr      (hst_addr),
      .rqm           (rqm),
      .dio           (dio),
      .ndma          (ndma),
      .busy          (busy),
      .seek_busy     (seek_busy),
      .phase         (phase),
      .bad_op        (info_q.bad_op),
      .core_xreq     (core_xreq),
      .core_xdata    (core_xdata),
      .core_res_byte (core_res_byte),
      .wr_req        (wr_req),
      .rd_req        (rd_req),
      .hst_rdata     (hst_rdata)
   );

   assign res_idx     = cnt;
   assign par_vld     = take_wr;
   assign par_data    = hst_wdata;
   assign par_idx     = cnt;
   assign xfer_rd_ack = take_rd && (phase == PH_EXEC);

endmodule

// File: tb/fdc_phase_seq_tb.sv
module fdc_phase_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_sel = 1'b0, hst_wr = 1'b0;
   logic [2:0] hst_addr = 3'd4;
   logic [7:0] hst_wdata = '0;
   logic [7:0] hst_rdata;
   logic       nondma_mode = 1'b0;
   logic [1:0] seek_busy = '0;
   logic       core_xreq = 1'b0, core_xdone = 1'b0;
   logic [7:0] core_xdata = '0;
   logic [7:0] core_res_byte;
   logic [3:0] res_idx, par_idx;
   logic       cmd_go, par_vld, xfer_rd_ack;
   logic [7:0] cmd_op, par_data;

   int checks = 0, errors = 0, go_cnt = 0;
   logic [7:0] go_op = '0;
   bit done = 0;
   logic last_par;

   always #4 clk = ~clk;

   assign core_res_byte = {4'hA, res_idx};

   fdc_phase_seq u_dut (
      .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .nondma_mode(nondma_mode), .seek_busy(seek_busy),
      .core_xreq(core_xreq), .core_xdata(core_xdata), .core_xdone(core_xdone),
      .core_res_byte(core_res_byte), .res_idx(res_idx), .cmd_go(cmd_go),
      .cmd_op(cmd_op), .par_vld(par_vld), .par_data(par_data),
      .par_idx(par_idx), .xfer_rd_ack(xfer_rd_ack)
   );

   always @(negedge clk) if (cmd_go) begin go_cnt++; go_op = cmd_op; end

   // bench-side command table
   function automatic int b_len(input logic [7:0] op);
      case (op[4:0])
         5'h0F: return 3; 5'h07: return 2; 5'h08: return 1;
         5'h06, 5'h05: return 9;
         default: return 1;
      endcase
   endfunction
   function automatic int b_res(input logic [7:0] op);
      case (op[4:0])
         5'h0F, 5'h07: return 0; 5'h08: return 2;
         5'h06, 5'h05: return 7;
         default: return 1;
      endcase
   endfunction
   function automatic bit b_exec(input logic [7:0] op);
      return (op[4:0] == 5'h06) || (op[4:0] == 5'h05);
   endfunction
   function automatic bit b_bad(input logic [7:0] op);
      return !(op[4:0] inside {5'h0F, 5'h07, 5'h08, 5'h06, 5'h05});
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic peek(output logic [7:0] s);
      hst_addr = 3'd4; #1; s = hst_rdata;
   endtask

   task automatic data_wr(input logic [7:0] b);
      @(negedge clk); hst_sel = 1; hst_wr = 1; hst_addr = 3'd5; hst_wdata = b;
      #1; last_par = par_vld;
      @(negedge clk); hst_sel = 0; hst_wr = 0;
   endtask

   task automatic data_rd(output logic [7:0] d);
      @(negedge clk); hst_sel = 1; hst_wr = 0; hst_addr = 3'd5; #1; d = hst_rdata;
      @(negedge clk); hst_sel = 0;
   endtask

   // gap status right after an access, then status one clock later
   task automatic chk_pair(input string req, input logic [7:0] gap, input logic [7:0] rec);
      logic [7:0] s;
      peek(s); chk(req, "gap status", s, gap);
      @(negedge clk); peek(s); chk(req, "status after gap", s, rec);
   endtask

   task automatic run_cmd(input logic [7:0] op, input bit ndma, input int nx);
      logic [7:0] s, d, sk, dirb, tail_g, tail_r;
      int l, r, g0;
      sk = {6'd0, seek_busy};
      l = b_len(op); r = b_res(op);
      dirb = (op[4:0] == 5'h06) ? 8'h40 : 8'h00;
      nondma_mode = ndma;
      g0 = go_cnt;
      peek(s); chk("R1", "idle status", s, 8'h80 | sk);
      if (b_exec(op)) begin
         tail_g = (ndma ? 8'h30 : 8'h10) | dirb; tail_r = tail_g;
      end else if (r > 0) begin
         tail_g = 8'h50; tail_r = 8'hD0;
      end else begin
         tail_g = 8'h00; tail_r = 8'h80;
      end
      for (int i = 0; i < l; i++) begin
         data_wr(i == 0 ? op : 8'($urandom));
         chk("R12", "byte accepted", {7'd0, last_par}, 8'h01);
         if (i < l - 1) chk_pair("R4", 8'h10 | sk, 8'h90 | sk);
         else           chk_pair(r == 0 ? "R5" : "R6", tail_g | sk, tail_r | sk);
      end
      chk("R12", "go count", 8'(go_cnt - g0), 8'd1);
      chk("R12", "go opcode", go_op, op);
      if (b_exec(op)) begin
         if (ndma) begin
            for (int j = 0; j < nx; j++) begin
               logic [7:0] xb;
               xb = 8'($urandom);
               @(negedge clk); core_xreq = 1; core_xdata = xb;
               @(negedge clk); core_xreq = 0;
               peek(s); chk("R9", "exec ready", s, 8'hB0 | dirb | sk);
               if (dirb != 0) begin
                  data_rd(d); chk("R9", "exec read byte", d, xb);
               end else begin
                  data_wr(xb); chk("R8", "exec write taken", {7'd0, last_par}, 8'h01);
               end
               chk_pair("R9", 8'h30 | dirb | sk, 8'h30 | dirb | sk);
            end
         end else begin
            repeat (3) @(negedge clk);
            peek(s); chk("R10", "dma exec status", s, 8'h10 | dirb | sk);
         end
         @(negedge clk); core_xdone = 1;
         @(negedge clk); core_xdone = 0;
         chk_pair("R8", 8'h50 | sk, 8'hD0 | sk);
      end
      for (int k = 0; k < r; k++) begin
         data_rd(d);
         chk(b_bad(op) ? "R7" : "R6", "result byte", d, b_bad(op) ? 8'h80 : (8'hA0 | 8'(k)));
         if (k < r - 1) chk_pair("R4", 8'h50 | sk, 8'hD0 | sk);
         else           chk_pair("R4", 8'h00 | sk, 8'h80 | sk);
      end
   endtask

   initial begin
      logic [7:0] s, d;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      peek(s); chk("R1", "reset status", s, 8'h80);

      // R11: drive bits follow seek inputs while idle
      seek_busy = 2'b10; peek(s); chk("R11", "drive1 busy", s, 8'h82);
      seek_busy = 2'b01; peek(s); chk("R11", "drive0 busy", s, 8'h81);
      seek_busy = 2'b00;

      // R3: read of data register while direction is write is ignored
      data_rd(d); peek(s); chk("R3", "wrong-direction read", s, 8'h80);

      // R2 / R3: seek with a status read and a gap-cycle write in between
      data_wr(8'h0F);
      hst_sel = 1; hst_wr = 1; hst_addr = 3'd5; hst_wdata = 8'h55;   // during gap
      @(negedge clk); hst_sel = 0; hst_wr = 0;
      peek(s); chk("R3", "gap write ignored", s, 8'h90);
      @(negedge clk); hst_sel = 1; hst_wr = 0; hst_addr = 3'd4;
      repeat (3) @(negedge clk);
      hst_sel = 0; peek(s); chk("R2", "status reads no effect", s, 8'h90);
      data_wr(8'h01); chk_pair("R3", 8'h10, 8'h90);
      data_wr(8'h22); chk_pair("R5", 8'h00, 8'h80);

      // R3: write during result phase ignored
      data_wr(8'h08); chk_pair("R6", 8'h50, 8'hD0);
      data_wr(8'h99); peek(s); chk("R3", "write in result ignored", s, 8'hD0);
      data_rd(d); chk("R6", "sense first result", d, 8'hA0);
      chk_pair("R4", 8'h50, 8'hD0);
      data_rd(d); chk("R6", "sense second result", d, 8'hA1);
      chk_pair("R4", 8'h00, 8'h80);

      // directed command types
      run_cmd(8'h07, 1'b0, 0);
      run_cmd(8'h1F, 1'b0, 0);
      run_cmd(8'hE6, 1'b1, 3);
      run_cmd(8'h45, 1'b1, 2);
      run_cmd(8'h06, 1'b0, 0);

      // constrained random mix
      for (int n = 0; n < 40; n++) begin
         logic [7:0] op;
         case ($urandom_range(0, 5))
            0: op = 8'h0F; 1: op = 8'h07; 2: op = 8'h08;
            3: op = {3'($urandom), 5'h06};
            4: op = {3'($urandom), 5'h05};
            default: op = {3'($urandom), 5'h10 | 5'($urandom_range(0, 15))};
         endcase
         seek_busy = 2'($urandom);
         run_cmd(op, 1'($urandom), $urandom_range(1, 4));
      end
      seek_busy = 2'b00;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule